// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block runs the raster of a display pipeline. A pixel counter and a line counter step through a frame whose size is set by two registers: the number of pixel clocks per line and the number of half-lines per field. Only progressive scan is handled, so the line count is half of the half-line value. From the raster position the block drives four independent sync channels, an active-video window flag, and one-clock top-field and bottom-field event pulses for an interrupt controller.

Each sync channel has its own horizontal pulse, set by a start pixel and a stop pixel. It also has its own vertical pulse, whose rising and falling edges are each placed by a line number and a pixel offset within that line. A downstream stage that delays its pixels by a known amount can therefore get syncs shifted to cancel that delay, with no effect on the other channels. Configuration arrives over a plain single-cycle write port with no handshake and no read path. A write to the restart register puts the raster back at the start of a frame. In locked mode, a rising edge on an external sync input realigns the counters instead of letting them run free.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel counter counts 0 up to line length minus 1 and then wraps to 0. The line length is held in bits 15:0 of word address 0x01. With a horizontal pulse of start 0 and stop 4, hsync rises once every line-length clocks.
- R2: The line counter counts 1 up to half-lines/2 and then wraps to 1. It advances only when the pixel counter wraps. The half-line count is held in bits 15:0 of address 0x02. The frame period is line length × half-lines/2 clocks.
- R3: Channel c has a horizontal register whose bits 15:0 are the start pixel and bits 31:16 the stop pixel. If start ≤ stop, hsync[c] is high for start ≤ pixel < stop. If stop < start, hsync[c] is high for pixel ≥ start or pixel < stop. If start equals stop, hsync[c] stays low.
- R4: Channel c has a vertical line register and an offset register. Each holds the rise value in bits 15:0 and the fall value in bits 31:16. vsync[c] goes high in the cycle the raster is at (rise line, rise pixel) and goes low in the cycle it is at (fall line, fall pixel). Otherwise it holds its value. If both positions match in the same cycle, the rise wins.
- R5: The registers of channel c sit at 0x10 + 8c. The offsets within a channel are: +0 horizontal, +1 top vertical line, +2 top vertical offset, +3 bottom vertical line, +4 bottom vertical offset. Bottom and top addresses write the same storage, so both fields always hold identical settings.
- R6: The window start is at 0x04 and the window stop at 0x05. Each is packed as line in bits 31:16 and pixel in bits 15:0. Addresses 0x06 and 0x07 write the same two registers. active_o is high when {line, pixel} lies between start and stop, with both ends included.
- R7: Address 0x00 bit 0 selects the mode: 0 is free-running and 1 is locked. In locked mode, a clock edge that samples ext_sync_in high after a low sample loads pixel 0 and line 1. In free-running mode ext_sync_in has no effect.
- R8: A write to 0x03 with bit 0 set loads pixel 0 and line 1 at that edge and clears all vertical pulse states. A write to 0x03 with bit 0 clear has no effect.
- R9: top_field_evt_o is high for the single cycle at line 1, pixel 0. bot_field_evt_o is high at line half-lines/4 + 1, pixel 0.
- R10: After reset the raster is at line 1, pixel 0, in free-running mode, with line length 20 and half-lines 20. All channel and window registers are zero, so every sync output and active_o are low.
- R11: A written value is in use from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe, one write per cycle |
| cfg_addr | input | 8 | Register word address |
| cfg_wr_data | input | 32 | Register write data |
| ext_sync_in | input | 1 | External sync used in locked mode |
| hsync_o | output | 4 | Horizontal sync, one bit per channel |
| vsync_o | output | 4 | Vertical sync, one bit per channel |
| active_o | output | 1 | Active-video window flag |
| top_field_evt_o | output | 1 | Top-field start pulse |
| bot_field_evt_o | output | 1 | Bottom-field start pulse |

## Verification
The bench targets these corner cases:
- A horizontal pulse that wraps past the end of the line. A design that treats stop < start as empty loses that channel.
- A vertical pulse that rises on the last line and falls early in the next frame. A design that matches only the line number moves the edge by the pixel offset.
- Equal start and stop values, and rise and fall positions on the same line.
- The bottom-field aliases. A design that keeps separate bottom storage never moves the channel programmed only through them.
- Totals shrunk while the raster lies beyond the new end. A design that wraps only on equality runs off the end of the frame.
- External pulses in both modes, and restart writes with bit 0 set and clear. Wrong handling shows up as a field event in the wrong cycle.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // Width of one packed field (pixel or line number)
  localparam int unsigned FW = 16;

  typedef logic [FW-1:0] fld_t;

  // Two fields in one register word: hi = bits 31:16, lo = bits 15:0
  typedef struct packed {
    fld_t hi;
    fld_t lo;
  } pair_t;

  typedef enum logic {
    RUN_FREE   = 1'b0,
    RUN_LOCKED = 1'b1
  } run_mode_e;

  // Register word addresses
  localparam int unsigned REG_MODE        = 0;
  localparam int unsigned REG_LINE_LEN    = 1;
  localparam int unsigned REG_HALF_LINES  = 2;
  localparam int unsigned REG_RESTART     = 3;
  localparam int unsigned REG_WIN_START   = 4;
  localparam int unsigned REG_WIN_STOP    = 5;
  localparam int unsigned REG_WIN_START_B = 6;
  localparam int unsigned REG_WIN_STOP_B  = 7;
  localparam int unsigned REG_CH_BASE     = 16;
  localparam int unsigned REG_CH_STRIDE   = 8;

  // Offsets inside one channel block
  localparam int unsigned OFS_HS   = 0;
  localparam int unsigned OFS_VL_T = 1;
  localparam int unsigned OFS_VO_T = 2;
  localparam int unsigned OFS_VL_B = 3;
  localparam int unsigned OFS_VO_B = 4;
endpackage

// File: rtl/rtg_cfg_regs.sv
module rtg_cfg_regs
  import rtg_pkg::*;
#(
  parameter int unsigned NCH            = 4,
  parameter int unsigned AW             = 8,
  parameter int unsigned RST_LINE_LEN   = 20,
  parameter int unsigned RST_HALF_LINES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  pair_t            wr_data_i,
  output run_mode_e        mode_o,
  output fld_t             line_len_o,
  output fld_t             half_lines_o,
  output pair_t            win_start_o,
  output pair_t            win_stop_o,
  output pair_t [NCH-1:0]  hs_o,
  output pair_t [NCH-1:0]  vl_o,
  output pair_t [NCH-1:0]  vo_o,
  output logic             restart_o
);
  localparam int unsigned CH_SH = $clog2(REG_CH_STRIDE);
  localparam int unsigned TW    = AW - CH_SH;

  localparam logic [AW-1:0] A_MODE  = AW'(REG_MODE);
  localparam logic [AW-1:0] A_LEN   = AW'(REG_LINE_LEN);
  localparam logic [AW-1:0] A_HALF  = AW'(REG_HALF_LINES);
  localparam logic [AW-1:0] A_RST   = AW'(REG_RESTART);
  localparam logic [AW-1:0] A_WS    = AW'(REG_WIN_START);
  localparam logic [AW-1:0] A_WE    = AW'(REG_WIN_STOP);
  localparam logic [AW-1:0] A_WS_B  = AW'(REG_WIN_START_B);
  localparam logic [AW-1:0] A_WE_B  = AW'(REG_WIN_STOP_B);

  localparam logic [CH_SH-1:0] O_HS   = CH_SH'(OFS_HS);
  localparam logic [CH_SH-1:0] O_VL_T = CH_SH'(OFS_VL_T);
  localparam logic [CH_SH-1:0] O_VO_T = CH_SH'(OFS_VO_T);
  localparam logic [CH_SH-1:0] O_VL_B = CH_SH'(OFS_VL_B);
  localparam logic [CH_SH-1:0] O_VO_B = CH_SH'(OFS_VO_B);

  assign restart_o = wr_en_i && (wr_addr_i == A_RST) && wr_data_i.lo[0];

  // Global registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o       <= RUN_FREE;
      line_len_o   <= fld_t'(RST_LINE_LEN);
      half_lines_o <= fld_t'(RST_HALF_LINES);
      win_start_o  <= '0;
      win_stop_o   <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_MODE)                          mode_o       <= run_mode_e'(wr_data_i.lo[0]);
      if (wr_addr_i == A_LEN)                           line_len_o   <= wr_data_i.lo;
      if (wr_addr_i == A_HALF)                          half_lines_o <= wr_data_i.lo;
      if ((wr_addr_i == A_WS) || (wr_addr_i == A_WS_B)) win_start_o  <= wr_data_i;
      if ((wr_addr_i == A_WE) || (wr_addr_i == A_WE_B)) win_stop_o   <= wr_data_i;
    end
  end

  // R11
  len_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_LEN) |=> (line_len_o == $past(wr_data_i.lo)));

  // Per-channel register blocks
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [TW-1:0] TAG = TW'(REG_CH_BASE / REG_CH_STRIDE + ch);

    logic             sel;
    logic [CH_SH-1:0] ofs;
    pair_t            hs_q, vl_q, vo_q;

    assign sel = wr_en_i && (wr_addr_i[AW-1:CH_SH] == TAG);
    assign ofs = wr_addr_i[CH_SH-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hs_q <= '0;
        vl_q <= '0;
        vo_q <= '0;
      end else if (sel) begin
        if (ofs == O_HS)                      hs_q <= wr_data_i;
        if ((ofs == O_VL_T) || (ofs == O_VL_B)) vl_q <= wr_data_i;
        if ((ofs == O_VO_T) || (ofs == O_VO_B)) vo_q <= wr_data_i;
      end
    end

    assign hs_o[ch] = hs_q;
    assign vl_o[ch] = vl_q;
    assign vo_o[ch] = vo_q;

    // R5
    bot_line_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && ofs == O_VL_B) |=> (vl_o[ch] == $past(wr_data_i)));

    // R5
    bot_ofs_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && ofs == O_VO_B) |=> (vo_o[ch] == $past(wr_data_i)));
  end
endmodule

// File: rtl/rtg_raster_ctr.sv
module rtg_raster_ctr
  import rtg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  fld_t      line_len_i,
  input  fld_t      half_lines_i,
  input  run_mode_e mode_i,
  input  logic      ext_sync_i,
  input  logic      restart_i,
  output fld_t      pix_o,
  output fld_t      line_o,
  output logic      top_evt_o,
  output logic      bot_evt_o
);
  fld_t pix_q, line_q;
  fld_t n_lines, bot_line;
  logic ext_q, ext_rise, realign;
  logic pix_end, last_line;

  always_comb begin
    n_lines   = half_lines_i >> 1;
    bot_line  = (half_lines_i >> 2) + fld_t'(1);
    ext_rise  = ext_sync_i && !ext_q;
    realign   = (mode_i == RUN_LOCKED) && ext_rise;
    pix_end   = (pix_q >= (line_len_i - fld_t'(1)));
    last_line = (line_q >= n_lines);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= fld_t'(1);
      ext_q  <= 1'b0;
    end else begin
      ext_q <= ext_sync_i;
      if (restart_i || realign) begin
        pix_q  <= '0;
        line_q <= fld_t'(1);
      end else if (pix_end) begin
        pix_q  <= '0;
        line_q <= last_line ? fld_t'(1) : (line_q + fld_t'(1));
      end else begin
        pix_q <= pix_q + fld_t'(1);
      end
    end
  end

  assign pix_o     = pix_q;
  assign line_o    = line_q;
  assign top_evt_o = (line_q == fld_t'(1)) && (pix_q == '0);
  assign bot_evt_o = (line_q == bot_line) && (pix_q == '0);

  // R1
  pix_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_end && !restart_i && !realign) |=> (pix_o == '0));

  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_end && last_line && !restart_i && !realign) |=> (line_o == fld_t'(1)));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> top_evt_o);

  // R7
  realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (realign && !restart_i) |=> top_evt_o);

  // R9
  top_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_evt_o && line_len_i > fld_t'(1) && !restart_i && !realign) |=> !top_evt_o);
endmodule

// File: rtl/rtg_sync_chan.sv
module rtg_sync_chan
  import rtg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  fld_t  pix_i,
  input  fld_t  line_i,
  input  pair_t hs_cfg_i,
  input  pair_t vl_cfg_i,
  input  pair_t vo_cfg_i,
  input  logic  clear_i,
  output logic  hsync_o,
  output logic  vsync_o
);
  fld_t hs_start, hs_stop;
  logic rise_hit, fall_hit;
  logic vs_q;

  // Horizontal pulse, wrapping when stop lies before start
  always_comb begin
    hs_start = hs_cfg_i.lo;
    hs_stop  = hs_cfg_i.hi;
    if (hs_start <= hs_stop)
      hsync_o = (pix_i >= hs_start) && (pix_i < hs_stop);
    else
      hsync_o = (pix_i >= hs_start) || (pix_i < hs_stop);
  end

  // Vertical pulse: each edge needs both line and pixel to match
  always_comb begin
    rise_hit = (line_i == vl_cfg_i.lo) && (pix_i == vo_cfg_i.lo);
    fall_hit = (line_i == vl_cfg_i.hi) && (pix_i == vo_cfg_i.hi);
    if (rise_hit)      vsync_o = 1'b1;
    else if (fall_hit) vsync_o = 1'b0;
    else               vsync_o = vs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vs_q <= 1'b0;
    else if (clear_i) vs_q <= 1'b0;
    else              vs_q <= vsync_o;
  end

  // R4
  vs_rise_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_o) |-> rise_hit);

  // R4
  vs_fall_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_o) |-> (fall_hit || $past(clear_i)));
endmodule

// File: rtl/rtg_window.sv
module rtg_window
  import rtg_pkg::*;
(
  input  fld_t  pix_i,
  input  fld_t  line_i,
  input  pair_t start_i,
  input  pair_t stop_i,
  output logic  active_o
);
  pair_t pos;

  // Line-major packed word: one unsigned compare orders (line, pixel)
  always_comb begin
    pos.hi   = line_i;
    pos.lo   = pix_i;
    active_o = (pos >= start_i) && (pos <= stop_i);
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned NCH            = 4,
  parameter int unsigned AW             = 8,
  parameter int unsigned RST_LINE_LEN   = 20,
  parameter int unsigned RST_HALF_LINES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [2*FW-1:0]   cfg_wr_data,
  input  logic              ext_sync_in,
  output logic [NCH-1:0]    hsync_o,
  output logic [NCH-1:0]    vsync_o,
  output logic              active_o,
  output logic              top_field_evt_o,
  output logic              bot_field_evt_o
);
  pair_t            wr_data;
  run_mode_e        mode;
  fld_t             line_len, half_lines;
  pair_t            win_start, win_stop;
  pair_t [NCH-1:0]  hs_cfg, vl_cfg, vo_cfg;
  logic             restart;
  fld_t             pix, line;

  assign wr_data = cfg_wr_data;

  rtg_cfg_regs #(
    .NCH            (NCH),
    .AW             (AW),
    .RST_LINE_LEN   (RST_LINE_LEN),
    .RST_HALF_LINES (RST_HALF_LINES)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (cfg_wr_en),
    .wr_addr_i    (cfg_addr),
    .wr_data_i    (wr_data),
    .mode_o       (mode),
    .line_len_o   (line_len),
    .half_lines_o (half_lines),
    .win_start_o  (win_start),
    .win_stop_o   (win_stop),
    .hs_o         (hs_cfg),
    .vl_o         (vl_cfg),
    .vo_o         (vo_cfg),
    .restart_o    (restart)
  );

  rtg_raster_ctr u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_len_i   (line_len),
    .half_lines_i (half_lines),
    .mode_i       (mode),
    .ext_sync_i   (ext_sync_in),
    .restart_i    (restart),
    .pix_o        (pix),
    .line_o       (line),
    .top_evt_o    (top_field_evt_o),
    .bot_evt_o    (bot_field_evt_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_sync
    rtg_sync_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .pix_i    (pix),
      .line_i   (line),
      .hs_cfg_i (hs_cfg[c]),
      .vl_cfg_i (vl_cfg[c]),
      .vo_cfg_i (vo_cfg[c]),
      .clear_i  (restart),
      .hsync_o  (hsync_o[c]),
      .vsync_o  (vsync_o[c])
    );
  end

  rtg_window u_win (
    .pix_i    (pix),
    .line_i   (line),
    .start_i  (win_start),
    .stop_i   (win_stop),
    .active_o (active_o)
  );
endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  localparam int NCH = 4;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, ext = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [NCH-1:0] hs, vs;
  logic act, tev, bev;

  always #10 clk = ~clk;   // 50 MHz

  raster_timing_gen u_raster_timing_gen (
    .clk (clk), .rst_n (rst_n), .cfg_wr_en (we), .cfg_addr (addr),
    .cfg_wr_data (wd), .ext_sync_in (ext), .hsync_o (hs), .vsync_o (vs),
    .active_o (act), .top_field_evt_o (tev), .bot_field_evt_o (bev)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "reset";

  // ---------------- behavioural reference model ----------------
  int m_mode, m_len, m_hl, m_ws, m_we, m_pix, m_line;
  int m_hs[NCH], m_vl[NCH], m_vo[NCH];
  bit m_vs[NCH];
  bit m_ext;

  function automatic bit e_hs(input int c);
    int st = m_hs[c] & 65535, sp = m_hs[c] >> 16;
    if (st <= sp) return (m_pix >= st) && (m_pix < sp);
    return (m_pix >= st) || (m_pix < sp);
  endfunction

  function automatic bit e_vs(input int c);
    if (m_line == (m_vl[c] & 65535) && m_pix == (m_vo[c] & 65535)) return 1'b1;
    if (m_line == (m_vl[c] >> 16) && m_pix == (m_vo[c] >> 16)) return 1'b0;
    return m_vs[c];
  endfunction

  function automatic bit e_act();
    int pos = m_line * 65536 + m_pix;
    return (pos >= m_ws) && (pos <= m_we);
  endfunction

  function automatic bit e_top();
    return (m_line == 1) && (m_pix == 0);
  endfunction

  function automatic bit e_bot();
    return (m_line == (m_hl / 4) + 1) && (m_pix == 0);
  endfunction

  task automatic model_write(input int a, input int d);
    if (a == 0) m_mode = d & 1;
    else if (a == 1) m_len = d & 65535;
    else if (a == 2) m_hl = d & 65535;
    else if (a == 4 || a == 6) m_ws = d;
    else if (a == 5 || a == 7) m_we = d;
    else if (a >= 16 && a < 16 + 8 * NCH) begin
      int c = (a - 16) / 8, o = a % 8;
      if (o == 0) m_hs[c] = d;
      else if (o == 1 || o == 3) m_vl[c] = d;
      else if (o == 2 || o == 4) m_vo[c] = d;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_len = 20; m_hl = 20; m_ws = 0; m_we = 0;
      m_pix = 0; m_line = 1; m_ext = 0;
      for (int c = 0; c < NCH; c++) begin
        m_hs[c] = 0; m_vl[c] = 0; m_vo[c] = 0; m_vs[c] = 0;
      end
    end else begin
      bit rise;
      rise = ext && !m_ext;
      if (we && addr == 8'd3 && wd[0]) begin
        m_pix = 0; m_line = 1;
        for (int c = 0; c < NCH; c++) m_vs[c] = 0;
      end else begin
        for (int c = 0; c < NCH; c++) m_vs[c] = e_vs(c);
        if (m_mode == 1 && rise) begin
          m_pix = 0; m_line = 1;
        end else if (m_pix >= m_len - 1) begin
          m_pix = 0;
          m_line = (m_line >= m_hl / 2) ? 1 : m_line + 1;
        end else begin
          m_pix++;
        end
      end
      m_ext = ext;
      if (we) model_write(int'(addr), int'(wd));
    end
  end

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] t=%0t: got %0d expected %0d", req, phase, $time, got, exp);
    end
  endtask

  // Per-clock comparison, away from the active edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) begin
        chk(hs[c] == e_hs(c), "R3 hsync", int'(hs[c]), int'(e_hs(c)));
        chk(vs[c] == e_vs(c), "R4 vsync", int'(vs[c]), int'(e_vs(c)));
      end
      chk(act == e_act(), "R6 window", int'(act), int'(e_act()));
      chk(tev == e_top(), "R9 top event", int'(tev), int'(e_top()));
      chk(bev == e_bot(), "R9 bottom event", int'(bev), int'(e_bot()));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #6;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  function automatic bit sig(input int w);
    case (w)
      0:       return hs[0];
      1:       return tev;
      2:       return bev;
      default: return vs[2];
    endcase
  endfunction

  // Cycles from a rise of signal f to the next rise of signal t
  task automatic gap(input int f, input int t, output int n);
    bit p, c;
    p = sig(f);
    for (int k = 0; k < 2000; k++) begin
      step(); c = sig(f);
      if (!p && c) break;
      p = c;
    end
    n = 0; p = sig(t);
    for (int k = 0; k < 2000; k++) begin
      step(); n++; c = sig(t);
      if (!p && c) break;
      p = c;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R10 outputs low while held in reset
    chk(hs == '0, "R10 hsync in reset", int'(hs), 0);
    chk(vs == '0, "R10 vsync in reset", int'(vs), 0);
    chk(act == 1'b0, "R10 active in reset", int'(act), 0);
    rst_n = 1'b1;
    step();
    chk(hs == '0 && vs == '0 && !act, "R10 outputs after reset", int'({hs, vs, act}), 0);

    phase = "program";
    wr(8'd16, 32'h0004_0000);   // ch0 hs start 0 stop 4
    wr(8'd17, 32'h0003_0001);   // ch0 vline rise 1 fall 3
    wr(8'd18, 32'h0000_0000);
    wr(8'd24, 32'h0009_0005);   // ch1 shifted by 5 pixels
    wr(8'd25, 32'h0003_0001);
    wr(8'd26, 32'h0005_0005);
    wr(8'd32, 32'h0003_0010);   // ch2 wrapping hsync 16..2
    wr(8'd35, 32'h0002_000A);   // ch2 through bottom aliases only
    wr(8'd36, 32'h000B_000B);
    wr(8'd40, 32'h0007_0007);   // ch3 empty hsync
    wr(8'd41, 32'h0004_0004);   // ch3 rise/fall on the same line
    wr(8'd42, 32'h0006_0002);
    wr(8'd4,  32'h0002_0003);   // window (2,3)..(9,16)
    wr(8'd5,  32'h0009_0010);

    phase = "restart";
    @(negedge clk); we = 1'b1; addr = 8'd3; wd = 32'h1;
    step();
    chk(tev == 1'b1, "R8 restart loads line 1 pixel 0", int'(tev), 1);
    @(negedge clk); we = 1'b0;

    phase = "periods";
    gap(0, 0, n); chk(n == 20, "R1 hsync period equals line length", n, 20);
    gap(1, 1, n); chk(n == 200, "R2 frame period", n, 200);
    gap(1, 3, n); chk(n == 191, "R5 alias-programmed vsync edge", n, 191);
    gap(1, 2, n); chk(n == 100, "R9 bottom event line", n, 100);
    repeat (400) step();

    phase = "write timing";
    wr(8'd5, 32'h7FFF_FFFF);
    @(negedge clk); we = 1'b1; addr = 8'd4; wd = 32'h0;
    step();
    chk(act == 1'b1, "R11 window start used next cycle", int'(act), 1);
    @(negedge clk); we = 1'b0;
    wr(8'd6, 32'h0002_0003);    // R6 restore via alias addresses
    wr(8'd7, 32'h0009_0010);
    repeat (60) step();

    phase = "free-running ext";
    repeat (7) step();
    @(negedge clk); ext = 1'b1;
    step();
    chk(tev == e_top(), "R7 ext ignored when free-running", int'(tev), int'(e_top()));
    @(negedge clk); ext = 1'b0;
    repeat (50) step();

    phase = "locked ext";
    wr(8'd0, 32'h1);
    repeat (33) step();
    @(negedge clk); ext = 1'b1;
    step();
    chk(tev == 1'b1, "R7 locked realign", int'(tev), 1);
    repeat (3) step();
    chk(tev == 1'b0, "R7 held ext does not realign again", int'(tev), 0);
    @(negedge clk); ext = 1'b0;
    repeat (117) step();
    @(negedge clk); ext = 1'b1;
    step();
    chk(tev == 1'b1, "R7 second realign", int'(tev), 1);
    @(negedge clk); ext = 1'b0;
    repeat (250) step();

    phase = "resize";
    wr(8'd0, 32'h0);
    repeat (45) step();
    @(negedge clk); we = 1'b1; addr = 8'd3; wd = 32'h2;
    step();
    chk(tev == e_top(), "R8 bit 0 clear has no effect", int'(tev), int'(e_top()));
    @(negedge clk); we = 1'b0;
    wr(8'd1, 32'd12);
    wr(8'd2, 32'd16);
    repeat (150) step();
    gap(1, 1, n); chk(n == 96, "R2 frame period after resize", n, 96);
    gap(1, 2, n); chk(n == 48, "R9 bottom event after resize", n, 48);
    repeat (300) step();

    done = 1;
    summary();
    $finish;
  end
endmodule